// File: doc/BRIEF.md
# Back Porch Gate Generator

This block drives an active-low gate during the back porch of each video line. The gate can control a DC-restore clamp or a level sampler that sits downstream. It watches a digitised composite sync (`csync_n`, where low means sync) and a vertical-interval flag from a vertical decoder. Each accepted trigger edge starts a one-shot. The one-shot first waits a fixed delay and then holds the gate low for a fixed width. Both values are counted in clock cycles, so a faster scan rate only needs smaller parameters.

The trigger edge is always the low-to-high transition of `csync_n`, but the qualification depends on where the edge falls. Outside the vertical interval, only the end of a normal horizontal sync counts: the low period before the edge must lie within a legal width window. Inside the vertical interval, every rising edge counts, serrations included. A running one-shot cannot be retriggered. While the loss-of-signal flag is raised, the gate stays inactive.

Top module: `bpg_gate_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no sync activity, `gate_n` is high (inactive).
- R2: With `vert_win` low, a low-to-high transition of `csync_n` triggers the one-shot if the preceding low period lasted from MIN_SYNC to MAX_SYNC sampled clock cycles, both limits included.
- R3: `gate_n` goes low DELAY_CYC clock cycles after the clock edge that samples the rising `csync_n`, and stays low for exactly WIDTH_CYC cycles.
- R4: With `vert_win` low, a rising `csync_n` that follows a low period shorter than MIN_SYNC or longer than MAX_SYNC cycles produces no gate pulse.
- R5: With `vert_win` high, every rising `csync_n` triggers the one-shot, whatever the length of the preceding low period.
- R6: A trigger that arrives during the delay or during the pulse is ignored. The pulse is neither restarted nor extended, and no second pulse follows.
- R7: While `sig_lost` is high, `gate_n` is high in the same cycle and triggers are ignored. A pulse in progress is cancelled and does not resume when `sig_lost` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csync_n | input | 1 | Digitised composite sync, low during sync |
| vert_win | input | 1 | High during the vertical interval |
| sig_lost | input | 1 | High while loss of input signal is flagged |
| gate_n | output | 1 | Back porch gate, active low |

## Verification
The bench builds the block with DELAY_CYC=3, WIDTH_CYC=8, MIN_SYNC=4 and MAX_SYNC=12. These small values put the exact start cycle and the pulse length within a short observation window. They also make every low-period boundary cheap to reach: 3, 4, 12 and 13 cycles, plus saturating lengths of 20 and 30. With these values, a second sync edge can be placed inside a running pulse, and the loss-of-signal flag can be raised mid-pulse, so the retrigger and cancel rules can be seen at the output cycle by cycle.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    OS_IDLE  = 2'd0,
    OS_WAIT  = 2'd1,
    OS_PULSE = 2'd2
  } os_state_e;

  // Bits needed to hold the value n (at least one).
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bpg_edge_qual.sv
module bpg_edge_qual #(
  parameter int MIN_SYNC = 700,
  parameter int MAX_SYNC = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  input  logic vert_win,
  output logic trig
);
  localparam int LW = bpg_pkg::cnt_bits(MAX_SYNC + 1);
  localparam logic [LW-1:0] SAT_V = LW'(MAX_SYNC + 1);
  localparam logic [LW-1:0] MIN_V = LW'(MIN_SYNC);
  localparam logic [LW-1:0] MAX_V = LW'(MAX_SYNC);

  logic          csync_q;
  logic [LW-1:0] low_cnt, low_cnt_nxt;
  logic          low_en;
  logic          rise, width_ok;

  // next-state
  always_comb begin
    low_en      = ~csync_n | (low_cnt != '0);
    low_cnt_nxt = '0;
    if (~csync_n) begin
      low_cnt_nxt = (low_cnt == SAT_V) ? SAT_V : low_cnt + LW'(1);
    end
  end

  assign rise     = csync_n & ~csync_q;
  assign width_ok = (low_cnt >= MIN_V) && (low_cnt <= MAX_V);
  assign trig     = rise & (vert_win | width_ok);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync_q <= 1'b1;
    end else begin
      csync_q <= csync_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (low_en) begin
      low_cnt <= low_cnt_nxt;
    end
  end

  // R2
  trig_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(csync_n) == 1'b0));

  // R4
  no_long_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !vert_win) |-> (low_cnt != SAT_V));

endmodule

// File: rtl/bpg_oneshot.sv
module bpg_oneshot #(
  parameter int DELAY_CYC = 64,
  parameter int WIDTH_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic kill,
  output logic gate_n
);
  import bpg_pkg::*;

  localparam int CMAX = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int CW   = cnt_bits(CMAX);
  localparam logic [CW-1:0] D_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] W_LAST = CW'(WIDTH_CYC - 1);

  os_state_e     state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_en;

  // next-state
  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    cnt_en    = 1'b0;
    unique case (state)
      OS_IDLE: begin
        if (trig) begin
          state_nxt = OS_WAIT;
          cnt_nxt   = '0;
          cnt_en    = 1'b1;
        end
      end
      OS_WAIT: begin
        cnt_en = 1'b1;
        if (cnt == D_LAST) begin
          state_nxt = OS_PULSE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + CW'(1);
        end
      end
      OS_PULSE: begin
        cnt_en = 1'b1;
        if (cnt == W_LAST) begin
          state_nxt = OS_IDLE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + CW'(1);
        end
      end
      default: begin
        state_nxt = OS_IDLE;
        cnt_nxt   = '0;
        cnt_en    = 1'b1;
      end
    endcase
    if (kill) begin
      state_nxt = OS_IDLE;
      cnt_nxt   = '0;
      cnt_en    = 1'b1;
    end
  end

  assign gate_n = ~((state == OS_PULSE) & ~kill);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= OS_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  // R3
  fall_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_n) |-> ($past(state) == OS_WAIT));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == OS_PULSE && trig && !kill) |=> (state != OS_WAIT));

endmodule

// File: rtl/bpg_gate_gen.sv
module bpg_gate_gen #(
  parameter int DELAY_CYC = 64,
  parameter int WIDTH_CYC = 600,
  parameter int MIN_SYNC  = 700,
  parameter int MAX_SYNC  = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  input  logic vert_win,
  input  logic sig_lost,
  output logic gate_n
);
  localparam int RW = bpg_pkg::cnt_bits(WIDTH_CYC + 1);
  localparam logic [RW-1:0] RUN_SAT = RW'(WIDTH_CYC + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(WIDTH_CYC);

  logic [1:0] rst_pipe;
  logic       rst_s_n;
  logic       trig, trig_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  bpg_edge_qual #(
    .MIN_SYNC (MIN_SYNC),
    .MAX_SYNC (MAX_SYNC)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .csync_n  (csync_n),
    .vert_win (vert_win),
    .trig     (trig)
  );

  assign trig_q = trig & ~sig_lost;

  bpg_oneshot #(
    .DELAY_CYC (DELAY_CYC),
    .WIDTH_CYC (WIDTH_CYC)
  ) u_shot (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .trig   (trig_q),
    .kill   (sig_lost),
    .gate_n (gate_n)
  );

  // Run-length monitor for the width check.
  logic [RW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_cnt <= '0;
    end else if (gate_n) begin
      run_cnt <= '0;
    end else if (run_cnt != RUN_SAT) begin
      run_cnt <= run_cnt + RW'(1);
    end
  end

  // R3
  width_limit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    run_cnt <= RUN_MAX);

  // R7
  lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sig_lost |-> gate_n);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_s_n |-> gate_n);

endmodule

// File: tb/bpg_gate_gen_bench.sv
`timescale 1ns/1ps
module bpg_gate_gen_bench;
  localparam int DLY = 3;
  localparam int WID = 8;
  localparam int MINS = 4;
  localparam int MAXS = 12;

  logic clk = 1'b0;
  logic rst_n, csync_n, vert_win, sig_lost;
  logic gate_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bpg_gate_gen #(
    .DELAY_CYC (DLY),
    .WIDTH_CYC (WID),
    .MIN_SYNC  (MINS),
    .MAX_SYNC  (MAXS)
  ) u_bpg_gate_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .csync_n  (csync_n),
    .vert_win (vert_win),
    .sig_lost (sig_lost),
    .gate_n   (gate_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Low period of len sampled cycles, then release at a falling clock edge.
  task automatic sync_pulse(input int len);
    @(negedge clk) csync_n = 1'b0;
    repeat (len) @(negedge clk);
    csync_n = 1'b1;
  endtask

  task automatic observe(input int win, output int first, output int lows);
    first = -1;
    lows  = 0;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (!gate_n) begin
        if (first < 0) first = i;
        lows++;
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; csync_n = 1'b1; vert_win = 1'b0; sig_lost = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate_n === 1'b1, "R1 in reset", int'(gate_n), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(gate_n === 1'b1, "R1 after release", int'(gate_n), 1);
  endtask

  task automatic t_hsync(input int len, input bit accept, input string req);
    int f, n;
    sync_pulse(len);
    observe(16, f, n);
    if (accept) begin
      chk(f == DLY + 1, {req, " start"}, f, DLY + 1);
      chk(n == WID, {req, " width"}, n, WID);
    end else begin
      chk(n == 0, {req, " rejected"}, n, 0);
    end
  endtask

  task automatic t_vert;
    vert_win = 1'b1;
    t_hsync(2, 1'b1, "R5 short in vertical");
    t_hsync(30, 1'b1, "R5 long in vertical");
    vert_win = 1'b0;
  endtask

  task automatic t_retrig;
    int f, n;
    sync_pulse(6);
    repeat (2) @(negedge clk);
    csync_n = 1'b0;
    repeat (5) @(negedge clk);
    csync_n = 1'b1;
    observe(20, f, n);
    chk(f == 1, "R6 pulse still running", f, 1);
    chk(n == 4, "R6 no extension or second pulse", n, 4);
  endtask

  task automatic t_lost;
    int f, n;
    sig_lost = 1'b1;
    sync_pulse(6);
    observe(16, f, n);
    chk(n == 0, "R7 no pulse while lost", n, 0);
    sig_lost = 1'b0;
    sync_pulse(6);
    repeat (5) @(negedge clk);
    chk(gate_n === 1'b0, "R7 pulse active before loss", int'(gate_n), 0);
    sig_lost = 1'b1;
    #1;
    chk(gate_n === 1'b1, "R7 immediate cancel", int'(gate_n), 1);
    @(negedge clk) sig_lost = 1'b0;
    observe(16, f, n);
    chk(n == 0, "R7 not resumed", n, 0);
  endtask

  initial begin
    t_reset();
    repeat (4) @(negedge clk);
    t_hsync(6, 1'b1, "R2 R3 nominal sync");
    t_hsync(MINS, 1'b1, "R2 min boundary");
    t_hsync(MAXS, 1'b1, "R2 max boundary");
    t_hsync(MINS - 1, 1'b0, "R4 below min");
    t_hsync(MAXS + 1, 1'b0, "R4 above max");
    t_hsync(20, 1'b0, "R4 broad outside vertical");
    t_vert();
    t_retrig();
    t_lost();
    t_hsync(6, 1'b1, "R2 after loss cleared");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule